// File: doc/BRIEF.md
# Transmitter Operating Mode Sequencer

This block steps a UHF transmitter through its power modes: off, a first start-up phase that waits for configuration and the oscillator, a second start-up phase in which the synthesizer settles, a clock-only mode, and two transmit modes. It runs on the crystal oscillator clock. Its inputs are the enable pin, the shared serial-data/transmit-data pin, a flag that marks the configuration word as fully loaded, the oscillator-ready flag, and two configuration bits: one selects clock-only operation, the other selects amplitude keying instead of frequency keying.

Synthesizer settling is timed with a counter rather than measured. The counter starts only once configuration and oscillator-ready have both been seen, whichever comes later. When it expires, the block raises the lock flag and enables the power amplifier. In amplitude keying the amplifier follows the live data bit. In frequency keying the amplifier stays on and the data bit only steers the frequency, which is outside this block.

Top module: `txmode_seq`

## Requirements
- R1: From off, enable high with the data pin low enters start-up phase 1 on the next clock. Enable high while the data pin is high leaves the block in off.
- R2: Start-up phase 1 is left only after both the configuration-loaded flag and the oscillator-ready flag have been seen high. Each may be a one-cycle pulse, and the later one decides. With clock-only clear, the block then enters start-up phase 2 and raises the PLL enable on the next clock.
- R3: The lock flag rises exactly LOCK_CYCLES (default 1280) clocks after start-up phase 2 is entered, and the PA enable is never high while the lock flag is low.
- R4: With clock-only set when both start conditions are met, the block enters clock-only mode and stays there with PLL enable and PA enable low until it is disabled.
- R5: Once locked, in frequency keying (keying select 0), or in amplitude keying with the data pin high, the block is in transmit mode 1 with PA enable high. In frequency keying, data changes do not alter this.
- R6: Once locked, in amplitude keying (keying select 1) with the data pin low, the block is in transmit mode 2 with PA enable low. It moves between the transmit modes one clock after each data change.
- R7: Enable low with the data pin low returns the block to off on the next clock from any mode. The settling counter restarts from zero on the next start-up, so a new lock again takes the full LOCK_CYCLES.
- R8: In off, the PLL enable, PA enable and lock flag are all low, and after reset the block is in off.
- R9: The mode output is one-hot: bit 0 off, bit 1 start-up phase 1, bit 2 start-up phase 2, bit 3 clock-only, bit 4 transmit mode 1, bit 5 transmit mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable pin level |
| data_i | input | 1 | Serial data / transmit data pin level |
| cfg_done_i | input | 1 | Configuration word fully loaded (level or pulse) |
| osc_rdy_i | input | 1 | Oscillator amplitude reached (level or pulse) |
| clk_only_i | input | 1 | Configuration bit selecting clock-only operation |
| ask_sel_i | input | 1 | Configuration bit: 1 amplitude keying, 0 frequency keying |
| mode_o | output | 6 | One-hot operating mode code |
| pll_en_o | output | 1 | Synthesizer enable |
| pa_en_o | output | 1 | Power amplifier enable, registered |
| lock_o | output | 1 | Synthesizer settling time elapsed |

## Verification
Start-up is driven in both orders. In one, configuration is loaded before the oscillator is ready. In the other, the oscillator flag pulses first and configuration completes later. This shows that the later event starts the settling timer and that one-cycle pulses are remembered. The lock flag is sampled one clock before and exactly at the end of the settling window, which separates the correct count from counts that are off by one. Data patterns after lock are applied under both keying selections, which distinguishes amplifier gating from frequency-only keying. A start-up aborted midway and then restarted shows that the counter does not resume from a stale value.

// File: rtl/txmode_pkg.sv
package txmode_pkg;

    localparam int MODE_W = 6;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF    = 6'b000001,
        MODE_START1 = 6'b000010,
        MODE_START2 = 6'b000100,
        MODE_CLKONLY= 6'b001000,
        MODE_TX1    = 6'b010000,
        MODE_TX2    = 6'b100000
    } mode_e;

endpackage

// File: rtl/txmode_start_gate.sv
// Remembers the configuration-loaded and oscillator-ready events while
// starting up, so the later of the two opens the gate.
module txmode_start_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic cfg_done_i,
    input  logic osc_rdy_i,
    output logic ready_o
);

    typedef struct packed {
        logic cfg_seen;
        logic osc_seen;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d = gate_q;
        if (clr_i) begin
            gate_d.cfg_seen = 1'b0;
            gate_d.osc_seen = 1'b0;
        end else begin
            if (cfg_done_i) gate_d.cfg_seen = 1'b1;
            if (osc_rdy_i)  gate_d.osc_seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end

    assign ready_o = (gate_q.cfg_seen | cfg_done_i) & (gate_q.osc_seen | osc_rdy_i);

endmodule

// File: rtl/txmode_lock_timer.sv
// Saturating settling counter: cleared while idle, counts while running.
module txmode_lock_timer #(
    parameter int LOCK_CYCLES = 1280
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic done_o
);

    localparam int CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clr_i) begin
            tmr_d.cnt = '0;
        end else if (run_i && (tmr_q.cnt != LAST)) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign done_o = run_i && (tmr_q.cnt == LAST);

endmodule

// File: rtl/txmode_fsm.sv
// Mode state machine with registered PLL, PA and lock outputs.
module txmode_fsm
    import txmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              data_i,
    input  logic              start_ok_i,
    input  logic              lock_done_i,
    input  logic              clk_only_i,
    input  logic              ask_sel_i,
    output mode_e             mode_o,
    output logic              pll_en_o,
    output logic              pa_en_o,
    output logic              lock_o
);

    typedef struct packed {
        mode_e mode;
        logic  pll;
        logic  pa;
        logic  lock;
    } fsm_t;

    fsm_t st_d, st_q;
    logic pa_on_w;

    // PA follows data only in amplitude keying
    assign pa_on_w = !ask_sel_i || data_i;

    always_comb begin
        st_d = st_q;
        if (!en_i && !data_i) begin
            st_d.mode = MODE_OFF;
            st_d.pll  = 1'b0;
            st_d.pa   = 1'b0;
            st_d.lock = 1'b0;
        end else begin
            unique case (st_q.mode)
                MODE_OFF: begin
                    if (en_i && !data_i) st_d.mode = MODE_START1;
                end
                MODE_START1: begin
                    if (start_ok_i) begin
                        if (clk_only_i) begin
                            st_d.mode = MODE_CLKONLY;
                        end else begin
                            st_d.mode = MODE_START2;
                            st_d.pll  = 1'b1;
                        end
                    end
                end
                MODE_START2: begin
                    if (lock_done_i) begin
                        st_d.lock = 1'b1;
                        st_d.mode = pa_on_w ? MODE_TX1 : MODE_TX2;
                        st_d.pa   = pa_on_w;
                    end
                end
                MODE_TX1, MODE_TX2: begin
                    st_d.mode = pa_on_w ? MODE_TX1 : MODE_TX2;
                    st_d.pa   = pa_on_w;
                end
                MODE_CLKONLY: begin
                    st_d.pll = 1'b0;
                    st_d.pa  = 1'b0;
                end
                default: begin
                    st_d.mode = MODE_OFF;
                    st_d.pll  = 1'b0;
                    st_d.pa   = 1'b0;
                    st_d.lock = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_OFF;
            st_q.pll  <= 1'b0;
            st_q.pa   <= 1'b0;
            st_q.lock <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o   = st_q.mode;
    assign pll_en_o = st_q.pll;
    assign pa_en_o  = st_q.pa;
    assign lock_o   = st_q.lock;

endmodule

// File: rtl/txmode_seq.sv
module txmode_seq
    import txmode_pkg::*;
#(
    parameter int LOCK_CYCLES = 1280
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              data_i,
    input  logic              cfg_done_i,
    input  logic              osc_rdy_i,
    input  logic              clk_only_i,
    input  logic              ask_sel_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              pll_en_o,
    output logic              pa_en_o,
    output logic              lock_o
);

    mode_e mode_w;
    logic  start_ok_w;
    logic  lock_done_w;
    logic  in_off_w;
    logic  in_start1_w;
    logic  in_start2_w;

    assign in_off_w    = (mode_w == MODE_OFF);
    assign in_start1_w = (mode_w == MODE_START1);
    assign in_start2_w = (mode_w == MODE_START2);

    txmode_start_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (in_off_w),
        .cfg_done_i (cfg_done_i),
        .osc_rdy_i  (osc_rdy_i),
        .ready_o    (start_ok_w)
    );

    txmode_lock_timer #(
        .LOCK_CYCLES (LOCK_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (in_off_w || in_start1_w),
        .run_i  (in_start2_w),
        .done_o (lock_done_w)
    );

    txmode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .data_i      (data_i),
        .start_ok_i  (start_ok_w),
        .lock_done_i (lock_done_w),
        .clk_only_i  (clk_only_i),
        .ask_sel_i   (ask_sel_i),
        .mode_o      (mode_w),
        .pll_en_o    (pll_en_o),
        .pa_en_o     (pa_en_o),
        .lock_o      (lock_o)
    );

    assign mode_o = mode_w;

endmodule

// File: rtl/txmode_seq_chk.sv
module txmode_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic       data_i,
    input logic       ask_sel_i,
    input logic [5:0] mode_o,
    input logic       pll_en_o,
    input logic       pa_en_o,
    input logic       lock_o
);

    AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(mode_o)); // R9

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o[0] |-> (!pll_en_o && !pa_en_o && !lock_o)); // R8

    AST_START1_NO_PLL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o[1] |-> !pll_en_o); // R2

    AST_PLL_FROM_START1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en_o) |-> $past(mode_o[1])); // R2

    AST_LOCK_FROM_START2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(mode_o[2])); // R3

    AST_PA_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        pa_en_o |-> lock_o); // R3

    AST_CLKONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o[3] |-> (!pll_en_o && !pa_en_o)); // R4

    AST_TX_PA_ON: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o[4] || mode_o[5]) && en_i && (!ask_sel_i || data_i))
        |=> (mode_o[4] && pa_en_o)); // R5

    AST_ASK_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o[4] || mode_o[5]) && en_i && ask_sel_i && !data_i)
        |=> (mode_o[5] && !pa_en_o)); // R6

    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !data_i) |=> mode_o[0]); // R7

endmodule

bind txmode_seq txmode_seq_chk u_chk (.*);

// File: tb/txmode_seq_bench.sv
module txmode_seq_bench;

    localparam int LOCK = 1280;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic       data_i = 1'b0;
    logic       cfg_done_i = 1'b0;
    logic       osc_rdy_i = 1'b0;
    logic       clk_only_i = 1'b0;
    logic       ask_sel_i = 1'b0;
    logic [5:0] mode_o;
    logic       pll_en_o;
    logic       pa_en_o;
    logic       lock_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [5:0] M_OFF = 6'b000001;
    localparam logic [5:0] M_S1  = 6'b000010;
    localparam logic [5:0] M_S2  = 6'b000100;
    localparam logic [5:0] M_CO  = 6'b001000;
    localparam logic [5:0] M_TX1 = 6'b010000;
    localparam logic [5:0] M_TX2 = 6'b100000;

    always #4 clk = ~clk;

    txmode_seq u_txmode_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .data_i     (data_i),
        .cfg_done_i (cfg_done_i),
        .osc_rdy_i  (osc_rdy_i),
        .clk_only_i (clk_only_i),
        .ask_sel_i  (ask_sel_i),
        .mode_o     (mode_o),
        .pll_en_o   (pll_en_o),
        .pa_en_o    (pa_en_o),
        .lock_o     (lock_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req, input logic [5:0] m,
                               input logic pll, input logic pa, input logic lk);
        check(req, "mode", 32'(mode_o), 32'(m));
        check(req, "pll_en", 32'(pll_en_o), 32'(pll));
        check(req, "pa_en", 32'(pa_en_o), 32'(pa));
        check(req, "lock", 32'(lock_o), 32'(lk));
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_off();
        en_i = 1'b0; data_i = 1'b0; cfg_done_i = 1'b0; osc_rdy_i = 1'b0;
        step(1);
    endtask

    // R8 R9: reset state
    task automatic t_reset();
        step(2);
        check_state("R8", M_OFF, 1'b0, 1'b0, 1'b0);
        check("R9", "onehot", 32'($countones(mode_o)), 32'd1);
    endtask

    // R1: enable with data high is not a start
    task automatic t_enable_gate();
        en_i = 1'b1; data_i = 1'b1;
        step(3);
        check("R1", "stay off with data high", 32'(mode_o), 32'(M_OFF));
        data_i = 1'b0;
        step(1);
        check_state("R1", M_S1, 1'b0, 1'b0, 1'b0);
        go_off();
    endtask

    // R2 R3 R5: configuration first, oscillator later, frequency keying
    task automatic t_fast_prog_fsk();
        ask_sel_i = 1'b0; clk_only_i = 1'b0;
        en_i = 1'b1; data_i = 1'b0;
        step(1);
        cfg_done_i = 1'b1;
        step(5);
        check_state("R2", M_S1, 1'b0, 1'b0, 1'b0);
        osc_rdy_i = 1'b1;
        step(1);
        check_state("R2", M_S2, 1'b1, 1'b0, 1'b0);
        step(LOCK - 1);
        check_state("R3", M_S2, 1'b1, 1'b0, 1'b0);
        step(1);
        check_state("R3", M_TX1, 1'b1, 1'b1, 1'b1);
        data_i = 1'b1;
        step(1);
        check_state("R5", M_TX1, 1'b1, 1'b1, 1'b1);
        data_i = 1'b0;
        step(1);
        check_state("R5", M_TX1, 1'b1, 1'b1, 1'b1);
        en_i = 1'b0; data_i = 1'b0;
        step(1);
        check_state("R7", M_OFF, 1'b0, 1'b0, 1'b0);
        go_off();
    endtask

    // R2 R3 R6: oscillator pulse first, configuration pulse later, amplitude keying
    task automatic t_slow_prog_ask();
        ask_sel_i = 1'b1; clk_only_i = 1'b0;
        en_i = 1'b1; data_i = 1'b0;
        step(1);
        osc_rdy_i = 1'b1;
        step(1);
        osc_rdy_i = 1'b0;
        for (int i = 0; i < 8; i++) begin
            data_i = i[0];
            step(1);
        end
        data_i = 1'b0;
        step(1);
        check_state("R2", M_S1, 1'b0, 1'b0, 1'b0);
        cfg_done_i = 1'b1;
        step(1);
        cfg_done_i = 1'b0;
        check_state("R2", M_S2, 1'b1, 1'b0, 1'b0);
        step(LOCK - 1);
        check("R3", "lock before window end", 32'(lock_o), 32'd0);
        step(1);
        check_state("R6", M_TX2, 1'b1, 1'b0, 1'b1);
        data_i = 1'b1;
        step(1);
        check_state("R6", M_TX1, 1'b1, 1'b1, 1'b1);
        data_i = 1'b0;
        step(1);
        check_state("R6", M_TX2, 1'b1, 1'b0, 1'b1);
        go_off();
        check_state("R7", M_OFF, 1'b0, 1'b0, 1'b0);
    endtask

    // R4: clock-only mode
    task automatic t_clock_only();
        clk_only_i = 1'b1; ask_sel_i = 1'b0;
        en_i = 1'b1; data_i = 1'b0;
        step(1);
        cfg_done_i = 1'b1; osc_rdy_i = 1'b1;
        step(1);
        check_state("R4", M_CO, 1'b0, 1'b0, 1'b0);
        step(LOCK + 10);
        check_state("R4", M_CO, 1'b0, 1'b0, 1'b0);
        go_off();
        check_state("R7", M_OFF, 1'b0, 1'b0, 1'b0);
        clk_only_i = 1'b0;
    endtask

    // R7: abort during settling, restart takes the full window
    task automatic t_abort_restart();
        ask_sel_i = 1'b0;
        en_i = 1'b1; data_i = 1'b0;
        step(1);
        cfg_done_i = 1'b1; osc_rdy_i = 1'b1;
        step(1);
        step(600);
        check_state("R7", M_S2, 1'b1, 1'b0, 1'b0);
        go_off();
        check_state("R7", M_OFF, 1'b0, 1'b0, 1'b0);
        en_i = 1'b1;
        step(1);
        check("R7", "start1 after restart", 32'(mode_o), 32'(M_S1));
        cfg_done_i = 1'b1; osc_rdy_i = 1'b1;
        step(1);
        step(LOCK - 1);
        check("R7", "no early lock after restart", 32'(lock_o), 32'd0);
        step(1);
        check_state("R7", M_TX1, 1'b1, 1'b1, 1'b1);
        go_off();
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        t_reset();
        t_enable_gate();
        t_fast_prog_fsk();
        t_slow_prog_ask();
        t_clock_only();
        t_abort_restart();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule